// File: doc/BRIEF.md
# Effective Address and Cycle-Penalty Unit

This unit resolves the final 16-bit memory address for the indexed and indirect operand modes of an 8-bit processor. It also reports whether an indexed read costs one extra cycle because it crossed into another 256-byte page. The sequencer presents a mode code, the one or two operand bytes that follow the opcode, both index registers, and whether the access is a read. It pulses `start` for one cycle. Direct modes finish one cycle later. The two pointer modes first fetch a little-endian pointer from page zero through a request/valid handshake, one byte per transaction, and then finish.

The same datapath also resolves relative branches. It takes the address of the next instruction, the signed 8-bit displacement held in the low operand byte, and the branch condition. It returns the address where execution continues and the number of cycles the branch takes. Opcode decoding, data reads and writes, and the fixed cost of stores and read-modify-write accesses are handled elsewhere.

Top module: `addr_resolve`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `ptrReq` and `pagePenalty` are 0, `effAddr` is 0x0000 and `branchCycles` is 0.
- R2: Mode 0 (page zero) yields {0x00, opLo}. Modes 1 and 2 (page zero indexed by X and by Y) yield {0x00, (opLo + index) mod 256}. The high byte is always 0x00. `done` pulses in the cycle after `start`.
- R3: Mode 3 (absolute) yields {opHi, opLo}. Modes 4 and 5 (absolute indexed by X and by Y) yield ({opHi, opLo} + index) mod 65536. `done` pulses in the cycle after `start`.
- R4: For a read (`isRead`=1) in modes 4, 5 or 7, `pagePenalty` is 1 exactly when the high byte of the unindexed base differs from the high byte of the final address. Every other mode reports 0.
- R5: When `isRead`=0 (store or read-modify-write), `pagePenalty` is 0 in every mode.
- R6: Mode 6 (pre-indexed pointer) requests the pointer low byte at (opLo + X) mod 256 and the high byte at the next page-zero location mod 256. The result is {high, low}.
- R7: Mode 7 (post-indexed pointer) requests the pointer bytes at opLo and at (opLo + 1) mod 256, so a pointer at 0xFF takes its high byte from 0x00. The result is ({high, low} + Y) mod 65536.
- R8: `ptrReq` stays high with a stable `ptrAddr` until `ptrValid` is sampled high, and `ptrData` is taken in that same cycle. `done` pulses in the cycle after the second accepted byte and is never high together with `ptrReq`.
- R9: Mode 8 (relative branch): if `taken` is 1 the result is `pc` + sign-extended opLo, otherwise it is `pc`. `branchCycles` is 2 when not taken, 3 when taken within the same page, and 4 when taken across a page. `branchCycles` is 0 in all other modes.
- R10: `start` is ignored while a pointer fetch is in progress. The pending result and pointer addresses are unaffected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving one operand |
| mode | input | 4 | Mode code, 0..8 as listed in the requirements |
| isRead | input | 1 | 1 for a read access, 0 for store or read-modify-write |
| opLo | input | 8 | First operand byte, or the branch displacement |
| opHi | input | 8 | Second operand byte |
| xIdx | input | 8 | X index register |
| yIdx | input | 8 | Y index register |
| pc | input | 16 | Address of the next instruction, used for branches |
| taken | input | 1 | Branch condition is true |
| ptrReq | output | 1 | Page-zero pointer byte request |
| ptrAddr | output | 8 | Page-zero location requested |
| ptrValid | input | 1 | Pointer byte is present on ptrData |
| ptrData | input | 8 | Pointer byte returned |
| effAddr | output | 16 | Resolved address or branch continuation |
| done | output | 1 | One-cycle result strobe |
| pagePenalty | output | 1 | Extra cycle for a page-crossing indexed read |
| branchCycles | output | 3 | Branch cycle count |

## Verification
The sweeps place base addresses at 0x00, 0x7F, 0xF0 and 0xFF in their page and use indices 0x00, 0x01, 0x80 and 0xFF. With these values, a design that let page-zero indexing carry into the high byte, or that took the penalty from the wrong carry, returns wrong addresses or flags. Pointers stored at location 0xFF catch a unit that fetches the high byte from 0x0100 instead of wrapping to 0x00. Branches from 0xFFF0, at page edges, and with displacements 0x7F and 0x80 expose sign-extension and page-compare errors as a wrong target or a cycle count off by one. Pointer replies are delayed while `start` pulses with other operands, which exposes a handshake that drops its address or accepts a second operation.

// File: rtl/addr_resolve_pkg.sv
package addr_resolve_pkg;

  localparam int CYC_W = 3;

  typedef enum logic [3:0] {
    AM_ZP   = 4'd0,
    AM_ZPX  = 4'd1,
    AM_ZPY  = 4'd2,
    AM_ABS  = 4'd3,
    AM_ABSX = 4'd4,
    AM_ABSY = 4'd5,
    AM_INDX = 4'd6,
    AM_INDY = 4'd7,
    AM_REL  = 4'd8
  } amode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // accept operands
    logic capLo;   // capture pointer low byte
    logic selHi;   // request pointer high byte
    logic finDir;  // finish a direct mode
    logic finPtr;  // finish a pointer mode
  } ar_strobe_t;

endpackage

// File: rtl/addr_resolve_ctrl.sv
module addr_resolve_ctrl
  import addr_resolve_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] mode,
  input  logic       ptrValid,
  output ar_strobe_t stb,
  output logic       ptrReq,
  output logic       busy
);

  typedef enum logic [1:0] {S_IDLE, S_PLO, S_PHI} st_t;
  st_t state, nextState;

  amode_t modeIn;
  logic   isPtr;

  assign modeIn = amode_t'(mode);
  assign isPtr  = (modeIn == AM_INDX) || (modeIn == AM_INDY);

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (start) begin
        stb.load   = 1'b1;
        stb.finDir = !isPtr;
        if (isPtr) nextState = S_PLO;
      end
      S_PLO: if (ptrValid) begin
        stb.capLo = 1'b1;
        nextState = S_PHI;
      end
      S_PHI: begin
        stb.selHi = 1'b1;
        if (ptrValid) begin
          stb.finPtr = 1'b1;
          nextState  = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  assign ptrReq = (state != S_IDLE);
  assign busy   = (state != S_IDLE);

endmodule

// File: rtl/addr_resolve_dp.sv
module addr_resolve_dp
  import addr_resolve_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ar_strobe_t        stb,
  input  logic [3:0]        mode,
  input  logic              isRead,
  input  logic [BYTE_W-1:0] opLo,
  input  logic [BYTE_W-1:0] opHi,
  input  logic [BYTE_W-1:0] xIdx,
  input  logic [BYTE_W-1:0] yIdx,
  input  logic [ADDR_W-1:0] pc,
  input  logic              taken,
  input  logic [BYTE_W-1:0] ptrData,
  output logic [BYTE_W-1:0] ptrAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              done,
  output logic              pagePenalty,
  output logic [CYC_W-1:0]  branchCycles
);

  localparam int PG = BYTE_W;  // lowest bit of the page number

  amode_t            modeIn, modeQ;
  logic              rdQ;
  logic [BYTE_W-1:0] yQ, baseQ, loQ;

  logic [BYTE_W-1:0] idxSel, zpSum;
  logic [ADDR_W-1:0] absBase, absSum, offExt, brTgt, dirAddr;
  logic              dirPen;
  logic [CYC_W-1:0]  dirCyc;
  logic [ADDR_W-1:0] ptrBase, ptrSum;
  logic              ptrPen;

  assign modeIn = amode_t'(mode);

  // direct modes, resolved from the live inputs at start
  always_comb begin
    idxSel  = (modeIn == AM_ZPY || modeIn == AM_ABSY) ? yIdx : xIdx;
    zpSum   = opLo + idxSel;
    absBase = {opHi, opLo};
    absSum  = absBase + ADDR_W'(idxSel);
    offExt  = {{BYTE_W{opLo[BYTE_W-1]}}, opLo};
    brTgt   = pc + offExt;
    dirAddr = absBase;
    dirPen  = 1'b0;
    dirCyc  = '0;
    case (modeIn)
      AM_ZP:            dirAddr = {{BYTE_W{1'b0}}, opLo};
      AM_ZPX, AM_ZPY:   dirAddr = {{BYTE_W{1'b0}}, zpSum};
      AM_ABS:           dirAddr = absBase;
      AM_ABSX, AM_ABSY: begin
        dirAddr = absSum;
        dirPen  = isRead && (absBase[PG] != absSum[PG]);
      end
      AM_REL: begin
        dirAddr = taken ? brTgt : pc;
        dirCyc  = taken ? (CYC_W'(3) + CYC_W'(brTgt[PG] ^ pc[PG])) : CYC_W'(2);
      end
      default: dirAddr = absBase;
    endcase
  end

  // pointer modes, resolved when the high byte arrives
  always_comb begin
    ptrBase = {ptrData, loQ};
    ptrSum  = ptrBase + ((modeQ == AM_INDY) ? ADDR_W'(yQ) : '0);
    ptrPen  = rdQ && (modeQ == AM_INDY) && (ptrBase[PG] != ptrSum[PG]);
  end

  assign ptrAddr = stb.selHi ? baseQ + BYTE_W'(1) : baseQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= AM_ZP;
      rdQ   <= 1'b0;
      yQ    <= '0;
      baseQ <= '0;
      loQ   <= '0;
    end else begin
      if (stb.load) begin
        modeQ <= modeIn;
        rdQ   <= isRead;
        yQ    <= yIdx;
        baseQ <= (modeIn == AM_INDX) ? zpSum : opLo;
      end
      if (stb.capLo) loQ <= ptrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      effAddr      <= '0;
      done         <= 1'b0;
      pagePenalty  <= 1'b0;
      branchCycles <= '0;
    end else begin
      done <= stb.finDir | stb.finPtr;
      if (stb.finDir) begin
        effAddr      <= dirAddr;
        pagePenalty  <= dirPen;
        branchCycles <= dirCyc;
      end else if (stb.finPtr) begin
        effAddr      <= ptrSum;
        pagePenalty  <= ptrPen;
        branchCycles <= '0;
      end
    end
  end

endmodule

// File: rtl/addr_resolve.sv
module addr_resolve
  import addr_resolve_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic              isRead,
  input  logic [BYTE_W-1:0] opLo,
  input  logic [BYTE_W-1:0] opHi,
  input  logic [BYTE_W-1:0] xIdx,
  input  logic [BYTE_W-1:0] yIdx,
  input  logic [ADDR_W-1:0] pc,
  input  logic              taken,
  output logic              ptrReq,
  output logic [BYTE_W-1:0] ptrAddr,
  input  logic              ptrValid,
  input  logic [BYTE_W-1:0] ptrData,
  output logic [ADDR_W-1:0] effAddr,
  output logic              done,
  output logic              pagePenalty,
  output logic [CYC_W-1:0]  branchCycles
);

  ar_strobe_t stb;
  logic       busy;

  addr_resolve_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .ptrValid (ptrValid),
    .stb      (stb),
    .ptrReq   (ptrReq),
    .busy     (busy)
  );

  addr_resolve_dp #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .mode         (mode),
    .isRead       (isRead),
    .opLo         (opLo),
    .opHi         (opHi),
    .xIdx         (xIdx),
    .yIdx         (yIdx),
    .pc           (pc),
    .taken        (taken),
    .ptrData      (ptrData),
    .ptrAddr      (ptrAddr),
    .effAddr      (effAddr),
    .done         (done),
    .pagePenalty  (pagePenalty),
    .branchCycles (branchCycles)
  );

endmodule

// File: rtl/addr_resolve_chk.sv
module addr_resolve_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        isRead,
  input logic [3:0]  mode,
  input logic        ptrReq,
  input logic        ptrValid,
  input logic [7:0]  ptrAddr,
  input logic        done,
  input logic [15:0] effAddr,
  input logic        pagePenalty,
  input logic [2:0]  branchCycles
);

  logic       rdHold;
  logic [3:0] modeHold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdHold   <= 1'b0;
      modeHold <= 4'd0;
    end else if (start && !busy) begin
      rdHold   <= isRead;
      modeHold <= mode;
    end
  end

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptrReq && !ptrValid) |=> (ptrReq && $stable(ptrAddr)));

  // R8
  req_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptrReq |-> !done);

  // R5
  store_no_penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rdHold) |-> !pagePenalty);

  // R4
  penalty_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pagePenalty) |-> (modeHold == 4'd4 || modeHold == 4'd5 || modeHold == 4'd7));

  // R9
  branch_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && modeHold == 4'd8) |-> (branchCycles >= 3'd2 && branchCycles <= 3'd4 && !pagePenalty));

  // R9
  nonbranch_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && modeHold != 4'd8) |-> (branchCycles == 3'd0));

  // R2
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && modeHold <= 4'd2) |-> (effAddr[15:8] == 8'h00));

endmodule

bind addr_resolve addr_resolve_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .isRead       (isRead),
  .mode         (mode),
  .ptrReq       (ptrReq),
  .ptrValid     (ptrValid),
  .ptrAddr      (ptrAddr),
  .done         (done),
  .effAddr      (effAddr),
  .pagePenalty  (pagePenalty),
  .branchCycles (branchCycles)
);

// File: tb/addr_resolve_tb.sv
module addr_resolve_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic        isRead = 1'b0;
  logic [7:0]  opLo = 8'd0, opHi = 8'd0, xIdx = 8'd0, yIdx = 8'd0;
  logic [15:0] pc = 16'd0;
  logic        taken = 1'b0;
  logic        ptrReq;
  logic [7:0]  ptrAddr;
  logic        ptrValid = 1'b0;
  logic [7:0]  ptrData = 8'd0;
  logic [15:0] effAddr;
  logic        done;
  logic        pagePenalty;
  logic [2:0]  branchCycles;

  int nChecks = 0;
  int nErr = 0;

  always #10 clk = ~clk;

  addr_resolve u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .isRead(isRead),
    .opLo(opLo), .opHi(opHi), .xIdx(xIdx), .yIdx(yIdx), .pc(pc), .taken(taken),
    .ptrReq(ptrReq), .ptrAddr(ptrAddr), .ptrValid(ptrValid), .ptrData(ptrData),
    .effAddr(effAddr), .done(done), .pagePenalty(pagePenalty), .branchCycles(branchCycles)
  );

  function automatic logic [7:0] zpByte(input logic [7:0] a);
    logic [7:0] r;
    r = a * 8'd37 + 8'd11;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                       input logic [15:0] p, input bit tk, rd,
                       output logic [15:0] a, output logic pen, output logic [2:0] cyc);
    logic [7:0]  t, p0, p1;
    logic [15:0] b, off, tgt;
    pen = 1'b0; cyc = 3'd0; a = 16'h0;
    case (m)
      4'd0: a = {8'h00, lo};
      4'd1: begin t = lo + x; a = {8'h00, t}; end
      4'd2: begin t = lo + y; a = {8'h00, t}; end
      4'd3: a = {hi, lo};
      4'd4, 4'd5: begin
        b = {hi, lo};
        a = b + {8'h00, (m == 4'd4) ? x : y};
        pen = rd && (b[15:8] != a[15:8]);
      end
      4'd6: begin
        p0 = lo + x; p1 = p0 + 8'd1;
        a = {zpByte(p1), zpByte(p0)};
      end
      4'd7: begin
        p0 = lo; p1 = lo + 8'd1;
        b = {zpByte(p1), zpByte(p0)};
        a = b + {8'h00, y};
        pen = rd && (b[15:8] != a[15:8]);
      end
      default: begin
        off = lo[7] ? {8'hFF, lo} : {8'h00, lo};
        tgt = p + off;
        a = tk ? tgt : p;
        cyc = !tk ? 3'd2 : ((tgt[15:8] != p[15:8]) ? 3'd4 : 3'd3);
      end
    endcase
  endtask

  task automatic runOp(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                       input logic [15:0] p, input bit tk, rd, input int lat,
                       input bit poke, input string tag);
    logic [15:0] ea;
    logic        pen;
    logic [2:0]  cyc;
    logic [7:0]  pa0, pa1, pa;
    string       penTag;
    model(m, lo, hi, x, y, p, tk, rd, ea, pen, cyc);
    penTag = rd ? "R4" : "R5";
    @(negedge clk);
    mode = m; opLo = lo; opHi = hi; xIdx = x; yIdx = y; pc = p; taken = tk; isRead = rd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (m == 4'd6 || m == 4'd7) begin
      pa0 = (m == 4'd6) ? lo + x : lo;
      pa1 = pa0 + 8'd1;
      for (int ph = 0; ph < 2; ph++) begin
        pa = (ph == 0) ? pa0 : pa1;
        for (int w = 0; w < lat; w++) begin
          // R8 request held while waiting, R10 start ignored
          chk(ptrReq && ptrAddr == pa && !done, poke ? "R10 hold under start" : "R8 hold", {8'h00, ptrAddr}, {8'h00, pa});
          if (poke) begin start = 1'b1; mode = 4'd0; opLo = ~lo; end
          @(negedge clk);
          start = 1'b0;
        end
        chk(ptrReq && ptrAddr == pa, {tag, " ptr address"}, {8'h00, ptrAddr}, {8'h00, pa});
        ptrValid = 1'b1;
        ptrData = zpByte(pa);
        @(negedge clk);
        ptrValid = 1'b0;
      end
    end
    chk(done && !ptrReq, {tag, " done strobe"}, {15'h0, done}, 16'h1);
    chk(effAddr == ea, {tag, " address"}, effAddr, ea);
    chk(pagePenalty == pen, {penTag, " penalty"}, {15'h0, pagePenalty}, {15'h0, pen});
    chk(branchCycles == cyc, "R9 cycles", {13'h0, branchCycles}, {13'h0, cyc});
    @(negedge clk);
    chk(!done && !ptrReq, {tag, " single pulse"}, {14'h0, done, ptrReq}, 16'h0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  localparam logic [7:0] IDX [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
  localparam logic [7:0] LOS [5] = '{8'h00, 8'h01, 8'h7F, 8'hF0, 8'hFF};
  localparam logic [7:0] HIS [3] = '{8'h00, 8'h12, 8'hFF};
  localparam logic [7:0] PLO [5] = '{8'h00, 8'h40, 8'h7F, 8'hFE, 8'hFF};
  localparam logic [7:0] PIX [4] = '{8'h00, 8'h01, 8'h80, 8'hFF};
  localparam logic [15:0] PCS [6] = '{16'h0000, 16'h0005, 16'h1080, 16'h10FE, 16'h12FF, 16'hFFF0};
  localparam logic [7:0] OFS [7] = '{8'h00, 8'h01, 8'h02, 8'h10, 8'h7F, 8'h80, 8'hFF};

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!done && !ptrReq && !pagePenalty && effAddr == 16'h0 && branchCycles == 3'd0,
        "R1 in reset", effAddr, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 after release
    chk(!done && !ptrReq && !pagePenalty && effAddr == 16'h0 && branchCycles == 3'd0,
        "R1 after reset", effAddr, 16'h0);

    // R2 page-zero modes
    for (int i = 0; i < 16; i++)
      for (int k = 0; k < 5; k++) begin
        runOp(4'd0, 8'(i * 17), 8'hAA, IDX[k], 8'h55, 16'h0, 1'b0, 1'b1, 0, 1'b0, "R2");
        runOp(4'd1, 8'(i * 17), 8'hAA, IDX[k], 8'h33, 16'h0, 1'b0, 1'b1, 0, 1'b0, "R2");
        runOp(4'd2, 8'(i * 17), 8'hAA, 8'h33, IDX[k], 16'h0, 1'b0, 1'b1, 0, 1'b0, "R2");
      end

    // R3 absolute modes, R4/R5 penalty
    for (int h = 0; h < 3; h++)
      for (int l = 0; l < 5; l++)
        for (int k = 0; k < 5; k++)
          for (int r = 0; r < 2; r++) begin
            runOp(4'd3, LOS[l], HIS[h], IDX[k], IDX[k], 16'h0, 1'b0, r[0], 0, 1'b0, "R3");
            runOp(4'd4, LOS[l], HIS[h], IDX[k], 8'h00, 16'h0, 1'b0, r[0], 0, 1'b0, "R3");
            runOp(4'd5, LOS[l], HIS[h], 8'h00, IDX[k], 16'h0, 1'b0, r[0], 0, 1'b0, "R3");
          end

    // R6/R7 pointer modes with R8 latency
    for (int l = 0; l < 5; l++)
      for (int k = 0; k < 4; k++)
        for (int r = 0; r < 2; r++)
          for (int d = 0; d < 2; d++) begin
            runOp(4'd6, PLO[l], 8'h00, PIX[k], 8'hC3, 16'h0, 1'b0, r[0], d * 2, 1'b0, "R6");
            runOp(4'd7, PLO[l], 8'h00, 8'hC3, PIX[k], 16'h0, 1'b0, r[0], d * 2, 1'b0, "R7");
          end

    // R10 start pulses while a pointer fetch waits
    runOp(4'd7, 8'hFF, 8'h00, 8'h00, 8'hF0, 16'h0, 1'b0, 1'b1, 3, 1'b1, "R10");
    runOp(4'd6, 8'hF0, 8'h00, 8'h0F, 8'h00, 16'h0, 1'b0, 1'b1, 2, 1'b1, "R10");

    // R9 branches
    for (int p = 0; p < 6; p++)
      for (int o = 0; o < 7; o++)
        for (int t = 0; t < 2; t++)
          runOp(4'd8, OFS[o], 8'h00, 8'h00, 8'h00, PCS[p], t[0], 1'b1, 0, 1'b0, "R9");

    finishRun();
  end

endmodule